// File: doc/BRIEF.md
# Tree-Search Cached Branch Metric Unit

This block computes branch metrics for a trellis decoder when the fading channel is slow. Within one frame the faded candidate constellation points do not change. The block latches them when a frame-start pulse arrives. For each received I/Q sample it looks for the nearest candidate through a binary tournament of half-plane tests. Each test takes the sign of a linear function of the sample: twice the dot product of the sample with the difference of the two candidates, compared against the difference of their squared magnitudes. The branch metric towards each candidate is then the squared distance from that winning candidate to it, not the distance from the raw sample. The only value computed fresh for every symbol is the winner-to-sample residual.

The half-plane parameters (two direction terms and one scaled constant) and the candidate-to-candidate distances are each held in a per-pair cache with a valid bit. An entry is filled the first time a symbol needs it, and it is then only read until the next frame-start pulse clears every valid bit. A symbol that misses spends one extra cycle filling. For this reason the first symbols of a frame take longer and later symbols settle at the minimum latency. Producing the candidates and the add-compare-select stage are handled elsewhere.

Top module: `tsbm_top`

## Requirements
- R1: After reset `busy`, `done`, `winner`, `resid` and every metric are 0.
- R2: `winner` is the index of the latched candidate with the smallest squared Euclidean distance to the accepted sample. When distances tie, the lowest index wins.
- R3: On `done`, metric k (bits k*DW +: DW of `metrics_flat`, DW = 2*CW+2) equals the squared distance between candidate `winner` and candidate k. The metric of the winner itself is 0.
- R4: On `done`, `resid` equals the squared distance between the accepted sample and candidate `winner`.
- R5: Latency is counted in rising edges from the accepting edge up to and including the edge that raises `done`. It equals log2(NPTS) + 1, plus one for each tree level whose needed half-plane pairs are not all cached, plus one if any winner-to-candidate distance is uncached. A cached entry never changes until the next frame start.
- R6: `frame_start` clears all cached entries, so the first symbol after it again pays every miss. It also latches the new candidates from `cand_i_flat`/`cand_q_flat`, where candidate k sits at bits k*CW +: CW.
- R7: `sym_valid` while `busy` is high is ignored. It changes neither the result nor the latency of the symbol in flight.
- R8: `done` is high for exactly one cycle. `busy` is low in that cycle, and the outputs hold their values until the next `done`.
- R9: A `frame_start` while a symbol is in flight aborts that symbol, and no `done` follows for it.
- R10: Changes on the candidate inputs without `frame_start` have no effect on the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Latch candidates, clear caches, abort symbol |
| cand_i_flat | input | NPTS*CW | In-phase coordinates of candidates, signed |
| cand_q_flat | input | NPTS*CW | Quadrature coordinates of candidates, signed |
| sym_valid | input | 1 | Received sample present, taken when idle |
| rx_i | input | CW | Received in-phase value, signed |
| rx_q | input | CW | Received quadrature value, signed |
| busy | output | 1 | Symbol in flight |
| done | output | 1 | One-cycle result strobe |
| winner | output | log2(NPTS) | Index of nearest candidate |
| metrics_flat | output | NPTS*DW | Winner-to-candidate squared distances |
| resid | output | DW | Sample-to-winner squared distance |

## Verification
A corrupted valid bit shows up at the ports in one of two ways. A stuck-clear bit lengthens the latency of the very next symbol that uses the pair. A wrongly set bit would make the block read a stale or zero entry, so the winner or a metric differs from the brute-force model on the same `done`. Because the stimulus steps through every candidate as the winner, each pair is exercised. The cache state then shows as a latency sequence: the bench predicts it cycle by cycle, both within one frame and across a frame restart.

// File: rtl/tsbm_pkg.sv
package tsbm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LEVEL  = 2'd1,
        ST_METRIC = 2'd2
    } tsbm_state_e;

    // linear index of unordered pair (a,b), a<b, among n points
    function automatic int pair_index(input int a, input int b, input int n);
        return a * n - (a * (a + 1)) / 2 + (b - a - 1);
    endfunction

endpackage

// File: rtl/tsbm_bisect_store.sv
module tsbm_bisect_store
    import tsbm_pkg::*;
#(
    parameter int NPTS = 4,
    parameter int CW   = 6,
    parameter int PW   = 2 * CW + 4,
    localparam int NPAIR = NPTS * (NPTS - 1) / 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic [NPAIR-1:0]     fill_mask,
    input  logic signed [CW-1:0] cand_i [NPTS],
    input  logic signed [CW-1:0] cand_q [NPTS],
    output logic signed [PW-1:0] dx_o   [NPAIR],
    output logic signed [PW-1:0] dy_o   [NPAIR],
    output logic signed [PW-1:0] cc_o   [NPAIR],
    output logic [NPAIR-1:0]     valid_o
);

    logic signed [PW-1:0] dx_d [NPAIR];
    logic signed [PW-1:0] dx_q [NPAIR];
    logic signed [PW-1:0] dy_d [NPAIR];
    logic signed [PW-1:0] dy_q [NPAIR];
    logic signed [PW-1:0] cc_d [NPAIR];
    logic signed [PW-1:0] cc_q [NPAIR];
    logic [NPAIR-1:0]     valid_d, valid_q;

    always_comb begin
        dx_d    = dx_q;
        dy_d    = dy_q;
        cc_d    = cc_q;
        valid_d = valid_q;
        for (int a = 0; a < NPTS; a++) begin
            for (int b = a + 1; b < NPTS; b++) begin
                logic signed [PW-1:0] ai, aq, bi, bq;
                int p;
                p  = pair_index(a, b, NPTS);
                ai = PW'(cand_i[a]);
                aq = PW'(cand_q[a]);
                bi = PW'(cand_i[b]);
                bq = PW'(cand_q[b]);
                if (clear) begin
                    valid_d[p] = 1'b0;
                end else if (fill_mask[p] && !valid_q[p]) begin
                    valid_d[p] = 1'b1;
                    dx_d[p]    = bi - ai;
                    dy_d[p]    = bq - aq;
                    cc_d[p]    = (bi * bi + bq * bq) - (ai * ai + aq * aq);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int p = 0; p < NPAIR; p++) begin
                dx_q[p] <= '0;
                dy_q[p] <= '0;
                cc_q[p] <= '0;
            end
        end else begin
            valid_q <= valid_d;
            dx_q    <= dx_d;
            dy_q    <= dy_d;
            cc_q    <= cc_d;
        end
    end

    assign dx_o    = dx_q;
    assign dy_o    = dy_q;
    assign cc_o    = cc_q;
    assign valid_o = valid_q;

    AST_BISECT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (valid_q == '0)); // R6

    for (genvar g = 0; g < NPAIR; g++) begin : g_frozen
        AST_BISECT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_q[g] && !clear) |=> ($stable(dx_q[g]) && $stable(dy_q[g]) && $stable(cc_q[g]) && valid_q[g])); // R5
    end

endmodule

// File: rtl/tsbm_dist_store.sv
module tsbm_dist_store
    import tsbm_pkg::*;
#(
    parameter int NPTS = 4,
    parameter int CW   = 6,
    parameter int PW   = 2 * CW + 4,
    parameter int DW   = 2 * CW + 2,
    localparam int NPAIR = NPTS * (NPTS - 1) / 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic [NPAIR-1:0]     fill_mask,
    input  logic signed [CW-1:0] cand_i [NPTS],
    input  logic signed [CW-1:0] cand_q [NPTS],
    output logic [DW-1:0]        dist_o [NPAIR],
    output logic [NPAIR-1:0]     valid_o
);

    logic [DW-1:0]    dist_d [NPAIR];
    logic [DW-1:0]    dist_q [NPAIR];
    logic [NPAIR-1:0] valid_d, valid_q;

    always_comb begin
        dist_d  = dist_q;
        valid_d = valid_q;
        for (int a = 0; a < NPTS; a++) begin
            for (int b = a + 1; b < NPTS; b++) begin
                logic signed [PW-1:0] ei, eq, sq;
                int p;
                p  = pair_index(a, b, NPTS);
                ei = PW'(cand_i[a]) - PW'(cand_i[b]);
                eq = PW'(cand_q[a]) - PW'(cand_q[b]);
                sq = ei * ei + eq * eq;
                if (clear) begin
                    valid_d[p] = 1'b0;
                end else if (fill_mask[p] && !valid_q[p]) begin
                    valid_d[p] = 1'b1;
                    dist_d[p]  = DW'(sq);
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int p = 0; p < NPAIR; p++) begin
                dist_q[p] <= '0;
            end
        end else begin
            valid_q <= valid_d;
            dist_q  <= dist_d;
        end
    end

    assign dist_o  = dist_q;
    assign valid_o = valid_q;

    AST_DIST_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (valid_q == '0)); // R6

    AST_DIST_NO_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> (($past(valid_q) & ~valid_q) == '0)); // R5

    for (genvar g = 0; g < NPAIR; g++) begin : g_frozen
        AST_DIST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_q[g] && !clear) |=> $stable(dist_q[g])); // R5
    end

endmodule

// File: rtl/tsbm_side_test.sv
module tsbm_side_test #(
    parameter int CW = 6,
    parameter int PW = 2 * CW + 4
) (
    input  logic signed [PW-1:0] dx,
    input  logic signed [PW-1:0] dy,
    input  logic signed [PW-1:0] cc,
    input  logic signed [CW-1:0] rx_i,
    input  logic signed [CW-1:0] rx_q,
    output logic                 pick_b
);

    logic signed [PW-1:0] proj;

    // sample lies strictly on the far side of the bisector -> second point
    always_comb begin
        proj   = (dx * PW'(rx_i) + dy * PW'(rx_q)) <<< 1;
        pick_b = (proj > cc);
    end

endmodule

// File: rtl/tsbm_top.sv
module tsbm_top
    import tsbm_pkg::*;
#(
    parameter int NPTS = 4,
    parameter int CW   = 6,
    localparam int LEVELS = $clog2(NPTS),
    localparam int IW     = (LEVELS > 0) ? LEVELS : 1,
    localparam int LW     = $clog2(LEVELS + 1) + 1,
    localparam int NPAIR  = NPTS * (NPTS - 1) / 2,
    localparam int HALF   = NPTS / 2,
    localparam int PW     = 2 * CW + 4,
    localparam int DW     = 2 * CW + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_start,
    input  logic [NPTS*CW-1:0]   cand_i_flat,
    input  logic [NPTS*CW-1:0]   cand_q_flat,
    input  logic                 sym_valid,
    input  logic signed [CW-1:0] rx_i,
    input  logic signed [CW-1:0] rx_q,
    output logic                 busy,
    output logic                 done,
    output logic [IW-1:0]        winner,
    output logic [NPTS*DW-1:0]   metrics_flat,
    output logic [DW-1:0]        resid
);

    typedef struct packed {
        tsbm_state_e                 st;
        logic [LW-1:0]               lvl;
        logic signed [CW-1:0]        rx_i;
        logic signed [CW-1:0]        rx_q;
        logic [NPTS-1:0][IW-1:0]     wins;
        logic [NPTS-1:0][CW-1:0]     ci;
        logic [NPTS-1:0][CW-1:0]     cq;
        logic                        done;
        logic [IW-1:0]               winner;
        logic [NPTS-1:0][DW-1:0]     metrics;
        logic [DW-1:0]               resid;
    } tsbm_regs_t;

    tsbm_regs_t r_d, r_q;

    // latched candidates as signed arrays
    logic signed [CW-1:0] lc_i [NPTS];
    logic signed [CW-1:0] lc_q [NPTS];

    always_comb begin
        for (int k = 0; k < NPTS; k++) begin
            lc_i[k] = $signed(r_q.ci[k]);
            lc_q[k] = $signed(r_q.cq[k]);
        end
    end

    // cache stores
    logic [NPAIR-1:0]     bfill, bvalid, dfill, dvalid;
    logic signed [PW-1:0] b_dx [NPAIR];
    logic signed [PW-1:0] b_dy [NPAIR];
    logic signed [PW-1:0] b_cc [NPAIR];
    logic [DW-1:0]        d_val [NPAIR];

    tsbm_bisect_store #(.NPTS(NPTS), .CW(CW), .PW(PW)) bis_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (frame_start),
        .fill_mask (bfill),
        .cand_i    (lc_i),
        .cand_q    (lc_q),
        .dx_o      (b_dx),
        .dy_o      (b_dy),
        .cc_o      (b_cc),
        .valid_o   (bvalid)
    );

    tsbm_dist_store #(.NPTS(NPTS), .CW(CW), .PW(PW), .DW(DW)) dst_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (frame_start),
        .fill_mask (dfill),
        .cand_i    (lc_i),
        .cand_q    (lc_q),
        .dist_o    (d_val),
        .valid_o   (dvalid)
    );

    // tournament slots
    logic signed [PW-1:0] s_dx [HALF];
    logic signed [PW-1:0] s_dy [HALF];
    logic signed [PW-1:0] s_cc [HALF];
    logic [HALF-1:0]      s_pick;
    logic [HALF-1:0]      s_act;
    int                   s_pair [HALF];
    logic                 bmiss;

    always_comb begin
        int act_cnt;
        act_cnt = NPTS >> (int'(r_q.lvl) + 1);
        bmiss   = 1'b0;
        bfill   = '0;
        for (int s = 0; s < HALF; s++) begin
            int a, b;
            a         = int'(r_q.wins[2*s]);
            b         = int'(r_q.wins[2*s+1]);
            s_act[s]  = (s < act_cnt);
            s_pair[s] = pair_index(a, b, NPTS);
            s_dx[s]   = b_dx[s_pair[s]];
            s_dy[s]   = b_dy[s_pair[s]];
            s_cc[s]   = b_cc[s_pair[s]];
            if (s_act[s] && !bvalid[s_pair[s]]) begin
                bmiss = 1'b1;
            end
        end
        for (int s = 0; s < HALF; s++) begin
            if (r_q.st == ST_LEVEL && s_act[s] && bmiss) begin
                bfill[s_pair[s]] = 1'b1;
            end
        end
    end

    for (genvar s = 0; s < HALF; s++) begin : g_slot
        tsbm_side_test #(.CW(CW), .PW(PW)) side_i (
            .dx     (s_dx[s]),
            .dy     (s_dy[s]),
            .cc     (s_cc[s]),
            .rx_i   (r_q.rx_i),
            .rx_q   (r_q.rx_q),
            .pick_b (s_pick[s])
        );
    end

    // metric stage
    logic                 dmiss;
    logic [DW-1:0]        m_val [NPTS];
    logic [DW-1:0]        resid_now;

    always_comb begin
        int w;
        logic signed [PW-1:0] ei, eq;
        int kp [NPTS];
        w     = int'(r_q.wins[0]);
        dmiss = 1'b0;
        dfill = '0;
        for (int k = 0; k < NPTS; k++) begin
            if (k == w) begin
                kp[k]    = 0;
                m_val[k] = '0;
            end else begin
                kp[k]    = (k < w) ? pair_index(k, w, NPTS) : pair_index(w, k, NPTS);
                m_val[k] = d_val[kp[k]];
                if (!dvalid[kp[k]]) begin
                    dmiss = 1'b1;
                end
            end
        end
        for (int k = 0; k < NPTS; k++) begin
            if (k != w && r_q.st == ST_METRIC && dmiss) begin
                dfill[kp[k]] = 1'b1;
            end
        end
        ei        = PW'(r_q.rx_i) - PW'(lc_i[w]);
        eq        = PW'(r_q.rx_q) - PW'(lc_q[w]);
        resid_now = DW'(ei * ei + eq * eq);
    end

    // next-state
    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (frame_start) begin
            r_d.st  = ST_IDLE;
            r_d.lvl = '0;
            for (int k = 0; k < NPTS; k++) begin
                r_d.ci[k] = cand_i_flat[k*CW +: CW];
                r_d.cq[k] = cand_q_flat[k*CW +: CW];
            end
        end else begin
            case (r_q.st)
                ST_IDLE: begin
                    if (sym_valid) begin
                        r_d.st   = ST_LEVEL;
                        r_d.lvl  = '0;
                        r_d.rx_i = rx_i;
                        r_d.rx_q = rx_q;
                        for (int k = 0; k < NPTS; k++) begin
                            r_d.wins[k] = IW'(k);
                        end
                    end
                end
                ST_LEVEL: begin
                    if (!bmiss) begin
                        for (int s = 0; s < HALF; s++) begin
                            if (s_act[s]) begin
                                r_d.wins[s] = s_pick[s] ? r_q.wins[2*s+1] : r_q.wins[2*s];
                            end
                        end
                        r_d.lvl = r_q.lvl + 1'b1;
                        if (r_q.lvl == LW'(LEVELS - 1)) begin
                            r_d.st = ST_METRIC;
                        end
                    end
                end
                ST_METRIC: begin
                    if (!dmiss) begin
                        for (int k = 0; k < NPTS; k++) begin
                            r_d.metrics[k] = m_val[k];
                        end
                        r_d.winner = r_q.wins[0];
                        r_d.resid  = resid_now;
                        r_d.done   = 1'b1;
                        r_d.st     = ST_IDLE;
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy         = (r_q.st != ST_IDLE);
    assign done         = r_q.done;
    assign winner       = r_q.winner;
    assign metrics_flat = r_q.metrics;
    assign resid        = r_q.resid;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R8

    AST_ABORT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (!done && !busy)); // R9

    AST_SAMPLE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !frame_start) |=> ($stable(r_q.rx_i) && $stable(r_q.rx_q))); // R7

    AST_CANDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_start |=> ($stable(r_q.ci) && $stable(r_q.cq))); // R10

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !r_d.done |=> ($stable(winner) && $stable(resid) && $stable(metrics_flat))); // R8

endmodule

// File: tb/tsbm_top_tb_top.sv
module tsbm_top_tb_top;

    localparam int NPTS = 4;
    localparam int CW   = 6;
    localparam int DW   = 2 * CW + 2;
    localparam int IW   = 2;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 frame_start = 1'b0;
    logic [NPTS*CW-1:0]   cand_i_flat = '0;
    logic [NPTS*CW-1:0]   cand_q_flat = '0;
    logic                 sym_valid = 1'b0;
    logic signed [CW-1:0] rx_i = '0;
    logic signed [CW-1:0] rx_q = '0;
    logic                 busy, done;
    logic [IW-1:0]        winner;
    logic [NPTS*DW-1:0]   metrics_flat;
    logic [DW-1:0]        resid;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    int bci [NPTS];
    int bcq [NPTS];

    always #10 clk = ~clk;

    tsbm_top #(.NPTS(NPTS), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .cand_i_flat(cand_i_flat), .cand_q_flat(cand_q_flat),
        .sym_valid(sym_valid), .rx_i(rx_i), .rx_q(rx_q),
        .busy(busy), .done(done), .winner(winner),
        .metrics_flat(metrics_flat), .resid(resid)
    );

    // stimulus table: sample, hand-derived winner and latency (first frame)
    localparam int NV = 7;
    localparam int T_RI  [NV] = '{9, 11, -4, -9, 4, -2, 0};
    localparam int T_RQ  [NV] = '{4, 2, 9, -4, -9, 9, 0};
    localparam int T_WIN [NV] = '{0, 0, 1, 2, 3, 1, 0};
    localparam int T_LAT [NV] = '{6, 3, 5, 4, 3, 3, 4};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int sqd(input int ai, input int aq, input int bi, input int bq);
        return (ai - bi) * (ai - bi) + (aq - bq) * (aq - bq);
    endfunction

    function automatic int nearest(input int ri, input int rq);
        int best = 0;
        for (int k = 1; k < NPTS; k++) begin
            if (sqd(ri, rq, bci[k], bcq[k]) < sqd(ri, rq, bci[best], bcq[best])) best = k;
        end
        return best;
    endfunction

    task automatic new_frame(input int ci [NPTS], input int cq [NPTS]);
        @(negedge clk);
        for (int k = 0; k < NPTS; k++) begin
            cand_i_flat[k*CW +: CW] = CW'(ci[k]);
            cand_q_flat[k*CW +: CW] = CW'(cq[k]);
            bci[k] = ci[k];
            bcq[k] = cq[k];
        end
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    // send one sample; optionally keep sym_valid high with a decoy sample
    task automatic run_sym(input int ri, input int rq, input int spam, output int lat);
        int n = 0;
        @(negedge clk);
        rx_i = CW'(ri); rx_q = CW'(rq); sym_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        if (spam > 0) begin
            rx_i = 6'sd5; rx_q = 6'sd5;
        end else begin
            sym_valid = 1'b0;
        end
        lat = -1;
        while (n < 40) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (n >= spam) sym_valid = 1'b0;
            if (done) begin
                lat = n;
                break;
            end
        end
    endtask

    task automatic check_result(input int ri, input int rq, input string tag);
        int w = nearest(ri, rq);
        check(int'(winner) == w, {tag, " R2 winner"}, int'(winner), w);
        for (int k = 0; k < NPTS; k++) begin
            int e = sqd(bci[w], bcq[w], bci[k], bcq[k]);
            int a = int'(metrics_flat[k*DW +: DW]);
            check(a == e, {tag, " R3 metric"}, a, e);
        end
        check(int'(resid) == sqd(ri, rq, bci[w], bcq[w]), {tag, " R4 resid"},
              int'(resid), sqd(ri, rq, bci[w], bcq[w]));
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 20000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        int set1_i [NPTS] = '{10, -3, -10, 3};
        int set1_q [NPTS] = '{3, 10, -3, -10};
        int set2_i [NPTS] = '{5, -6, -5, 7};
        int set2_q [NPTS] = '{5, 4, -6, -4};
        int set3_i [NPTS] = '{-20, 20, 0, 1};
        int set3_q [NPTS] = '{0, 0, 20, -20};
        int lat;
        bit seen;

        repeat (3) @(negedge clk);
        // R1 reset state
        check(busy == 1'b0, "R1 busy", int'(busy), 0);
        check(done == 1'b0, "R1 done", int'(done), 0);
        check(winner == '0 && resid == '0, "R1 winner/resid", int'(resid), 0);
        check(metrics_flat == '0, "R1 metrics", int'(metrics_flat[DW-1:0]), 0);
        rst_n = 1'b1;

        new_frame(set1_i, set1_q);
        for (int v = 0; v < NV; v++) begin
            run_sym(T_RI[v], T_RQ[v], 0, lat);
            check(lat == T_LAT[v], "R5 latency", lat, T_LAT[v]);
            check(int'(winner) == T_WIN[v], "R2 table winner", int'(winner), T_WIN[v]);
            check_result(T_RI[v], T_RQ[v], "table");
            // R8 pulse and hold
            @(negedge clk);
            check(done == 1'b0, "R8 done pulse", int'(done), 0);
            check(int'(winner) == T_WIN[v], "R8 hold", int'(winner), T_WIN[v]);
        end

        // R6: new frame clears caches and takes new candidates
        new_frame(set2_i, set2_q);
        run_sym(4, 6, 0, lat);
        check(lat == 6, "R6 latency after clear", lat, 6);
        check_result(4, 6, "R6");

        // R10: candidate inputs change without frame_start
        @(negedge clk);
        for (int k = 0; k < NPTS; k++) begin
            cand_i_flat[k*CW +: CW] = CW'(set3_i[k]);
            cand_q_flat[k*CW +: CW] = CW'(set3_q[k]);
        end
        run_sym(4, 6, 0, lat);
        check(lat == 3, "R10 latency", lat, 3);
        check(int'(winner) == 0, "R10 winner", int'(winner), 0);
        check_result(4, 6, "R10");

        // R7: sym_valid held during busy with a decoy sample
        run_sym(-5, -5, 2, lat);
        check(lat == 5, "R7 latency", lat, 5);
        check(int'(winner) == 2, "R7 winner", int'(winner), 2);
        check_result(-5, -5, "R7");
        repeat (4) @(negedge clk);
        check(busy == 1'b0, "R7 no extra symbol", int'(busy), 0);

        // R9: abort via frame_start mid-symbol
        @(negedge clk);
        for (int k = 0; k < NPTS; k++) begin
            cand_i_flat[k*CW +: CW] = CW'(set2_i[k]);
            cand_q_flat[k*CW +: CW] = CW'(set2_q[k]);
        end
        rx_i = 6'sd4; rx_q = 6'sd6; sym_valid = 1'b1;
        @(negedge clk);
        sym_valid = 1'b0;
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        seen = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (done) seen = 1'b1;
        end
        check(seen == 1'b0, "R9 no done after abort", int'(seen), 0);
        run_sym(4, 6, 0, lat);
        check(lat == 6, "R6 R9 latency after abort", lat, 6);
        check_result(4, 6, "R9");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule